// File: doc/BRIEF.md
# Layered LDPC Schedule Controller

This block sequences a layered min-sum decoder for a quasi-cyclic LDPC code with 42x42 circulants and 16 block columns. It holds a short control sequence in an internal register array. Each entry names a check-node layer, a block column, a circulant shift and a layer-closing flag. The entries are loaded through a valid/ready port. After a start pulse the controller walks the sequence once per decoding iteration. For each entry it issues a read of the block column's log-likelihood-ratio word, together with the shift and the layer index. It issues the matching write-back a fixed pipeline depth later.

No forwarding path exists. If an entry's block column has a write-back still pending in the pipeline, issue halts and `stall` is raised until that write has retired. Decoding ends after the iteration limit, or early when the datapath pulses `early_term`. In the early case the current layer is finished first. `done` pulses with the write-back of the final entry. The load port follows valid/ready rules. An entry is written only in a cycle where both `ld_valid` and `ld_ready` are high. `ld_ready` is low from the accepted start until the cycle after `done`, so the sequence cannot change under a running decode.

Top module: `ldpc_layer_sched`

## Requirements
- R1: After reset the block is idle: `mem_rd_en`, `mem_wr_en`, `stall` and `done` are low, `iter_count` is 0 and `ld_ready` is 1.
- R2: When `ld_valid` and `ld_ready` are both high at a clock edge, the entry (`ld_layer`, `ld_col`, `ld_shift`, `ld_eol`) is stored at index `ld_idx`. `ld_ready` is low while a decode is in progress, and load attempts in that time leave the stored sequence unchanged.
- R3: A `start` pulse sampled while idle with a nonzero `seq_len` begins a decode, and the first read can occur in the next cycle. `start` is ignored while a decode is in progress or when `seq_len` is 0.
- R4: Entries 0 to `seq_len`-1 are issued in index order, and this pass repeats once per iteration. Each issued read drives `mem_rd_addr` with the entry's block column, `mem_rd_layer` with its layer and `shift_amt` with its shift.
- R5: A read of a block column is not issued until the cycle after the write-back of that column's previous read. While an entry is held for this reason, `stall` is high. Otherwise one entry is issued per clock.
- R6: Every read is followed after exactly PIPE_DEPTH cycles by one write-back cycle with `mem_wr_en` high and `mem_wr_addr` equal to the column that was read.
- R7: `iter_count` is the zero-based index of the iteration being issued. Decoding stops after entry `seq_len`-1 of iteration ITER_MAX-1, and `iter_count` holds its last value until the next start.
- R8: After an `early_term` pulse during issue, issue continues up to and including the first entry with the layer-closing flag set (or the last entry of the sequence) that issues in the pulse cycle or later. Nothing issues after that entry.
- R9: `done` is high for exactly one cycle, the cycle of the final entry's write-back. `ld_ready` is high in the following cycle.
- R10: `seq_len` is captured at start. Changes to it during a decode have no effect on that decode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a decode (pulse) |
| early_term | input | 1 | Early-termination pulse from the datapath |
| seq_len | input | 7 | Number of active sequence entries, sampled at start |
| ld_valid | input | 1 | Sequence load request |
| ld_ready | output | 1 | Load accepted; high while idle |
| ld_idx | input | 6 | Entry index to load |
| ld_layer | input | 3 | Layer index of the loaded entry |
| ld_col | input | 4 | Block column of the loaded entry |
| ld_shift | input | 6 | Circulant shift of the loaded entry |
| ld_eol | input | 1 | Layer-closing flag of the loaded entry |
| mem_rd_en | output | 1 | LLR memory read enable |
| mem_rd_addr | output | 4 | Block column being read |
| mem_rd_layer | output | 3 | Layer of the entry being read |
| shift_amt | output | 6 | Circulant shift of the entry being read |
| mem_wr_en | output | 1 | LLR memory write-back enable |
| mem_wr_addr | output | 4 | Block column being written back |
| stall | output | 1 | Issue held by a pending write to the same column |
| iter_count | output | 3 | Zero-based index of the current iteration |
| done | output | 1 | One-cycle pulse at the final write-back |

## Verification
The assertions assume that `seq_len` never exceeds the array depth, that `ld_col` stays below 16 and `ld_shift` below 42, and that every index below `seq_len` was loaded before start. The bench generates columns, shifts and lengths only inside those ranges and loads each sequence in full before its start pulse. The bench applies `early_term`, stray start pulses, load attempts and `seq_len` changes at arbitrary cycles of a decode. These inputs stay within the interface rules, so the pipeline never holds two pending writes to one column.

// File: rtl/ldpc_sched_pkg.sv
package ldpc_sched_pkg;

  typedef enum logic [1:0] {
    SCH_IDLE  = 2'd0,
    SCH_RUN   = 2'd1,
    SCH_DRAIN = 2'd2
  } sch_state_e;

  // width of an index that spans n values (never zero)
  function automatic int idx_bits(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/ldpc_seq_store.sv
module ldpc_seq_store #(
  parameter int DEPTH = 64,
  parameter int LW    = 3,
  parameter int CW    = 4,
  parameter int SW    = 6,
  parameter int IW    = 6
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] widx,
  input  logic [LW-1:0] wlayer,
  input  logic [CW-1:0] wcol,
  input  logic [SW-1:0] wshift,
  input  logic          weol,
  input  logic [IW-1:0] ridx,
  output logic [LW-1:0] rlayer,
  output logic [CW-1:0] rcol,
  output logic [SW-1:0] rshift,
  output logic          reol
);

  localparam int EW = LW + CW + SW + 1;

  logic [EW-1:0] ent_q [DEPTH];

  genvar gi;
  generate
    for (gi = 0; gi < DEPTH; gi++) begin : g_ent
      always_ff @(posedge clk) begin
        if (we && (widx == IW'(gi))) begin
          ent_q[gi] <= {wlayer, wcol, wshift, weol};
        end
      end
    end
  endgenerate

  logic [EW-1:0] rd_word;
  always_comb begin
    rd_word = ent_q[ridx];
    {rlayer, rcol, rshift, reol} = rd_word;
  end

endmodule

// File: rtl/ldpc_hazard_pipe.sv
module ldpc_hazard_pipe #(
  parameter int DEPTH = 4,
  parameter int CW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [CW-1:0] push_col,
  input  logic          push_final,
  input  logic [CW-1:0] probe_col,
  output logic          hazard,
  output logic          ret_valid,
  output logic [CW-1:0] ret_col,
  output logic          ret_final
);

  logic [DEPTH-1:0] vld_q;
  logic [DEPTH-1:0] fin_q;
  logic [CW-1:0]    col_q [DEPTH];
  logic [DEPTH-1:0] hit;

  genvar gs;
  generate
    for (gs = 0; gs < DEPTH; gs++) begin : g_stage
      if (gs == 0) begin : g_head
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            vld_q[gs] <= 1'b0;
            fin_q[gs] <= 1'b0;
            col_q[gs] <= '0;
          end else begin
            vld_q[gs] <= push;
            fin_q[gs] <= push && push_final;
            col_q[gs] <= push_col;
          end
        end
      end else begin : g_body
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            vld_q[gs] <= 1'b0;
            fin_q[gs] <= 1'b0;
            col_q[gs] <= '0;
          end else begin
            vld_q[gs] <= vld_q[gs-1];
            fin_q[gs] <= fin_q[gs-1];
            col_q[gs] <= col_q[gs-1];
          end
        end
      end
      assign hit[gs] = vld_q[gs] && (col_q[gs] == probe_col);
    end
  endgenerate

  assign hazard    = |hit;
  assign ret_valid = vld_q[DEPTH-1];
  assign ret_col   = col_q[DEPTH-1];
  assign ret_final = fin_q[DEPTH-1];

  genvar ga, gb;
  generate
    for (ga = 0; ga < DEPTH; ga++) begin : g_pa
      for (gb = ga + 1; gb < DEPTH; gb++) begin : g_pb
        // R5
        no_dup_inflight_chk: assert property (@(posedge clk) disable iff (!rst_n)
          !(vld_q[ga] && vld_q[gb] && (col_q[ga] == col_q[gb])));
      end
    end
  endgenerate

endmodule

// File: rtl/ldpc_sched_ctrl.sv
module ldpc_sched_ctrl
  import ldpc_sched_pkg::*;
#(
  parameter int ITER_MAX = 5,
  parameter int IW       = 6,
  parameter int LENW     = 7,
  parameter int ITW      = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            early_term,
  input  logic [LENW-1:0] seq_len,
  input  logic            cur_eol,
  input  logic            hazard,
  input  logic            ret_valid,
  input  logic            ret_final,
  output logic            issue,
  output logic            final_tag,
  output logic [IW-1:0]   ptr,
  output logic [ITW-1:0]  iter_count,
  output logic            stall,
  output logic            done,
  output logic            idle
);

  sch_state_e      state_q;
  logic [IW-1:0]   ptr_q;
  logic [ITW-1:0]  iter_q;
  logic [LENW-1:0] len_q;
  logic            et_q;

  logic running, last_entry, last_iter, et_now;

  always_comb begin
    running    = (state_q == SCH_RUN);
    idle       = (state_q == SCH_IDLE);
    issue      = running && !hazard;
    stall      = running && hazard;
    last_entry = (LENW'(ptr_q) == (len_q - LENW'(1)));
    last_iter  = (iter_q == ITW'(ITER_MAX - 1));
    et_now     = et_q || early_term;
    final_tag  = issue && ((last_entry && last_iter) ||
                           (et_now && (cur_eol || last_entry)));
    done       = (state_q == SCH_DRAIN) && ret_valid && ret_final;
    ptr        = ptr_q;
    iter_count = iter_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SCH_IDLE;
      ptr_q   <= '0;
      iter_q  <= '0;
      len_q   <= '0;
      et_q    <= 1'b0;
    end else begin
      unique case (state_q)
        SCH_IDLE: begin
          if (start && (seq_len != '0)) begin
            state_q <= SCH_RUN;
            ptr_q   <= '0;
            iter_q  <= '0;
            len_q   <= seq_len;
            et_q    <= 1'b0;
          end
        end
        SCH_RUN: begin
          if (early_term) et_q <= 1'b1;
          if (issue) begin
            if (final_tag) begin
              state_q <= SCH_DRAIN;
            end else if (last_entry) begin
              ptr_q  <= '0;
              iter_q <= iter_q + ITW'(1);
            end else begin
              ptr_q <= ptr_q + IW'(1);
            end
          end
        end
        SCH_DRAIN: begin
          if (done) state_q <= SCH_IDLE;
        end
        default: state_q <= SCH_IDLE;
      endcase
    end
  end

  // R7
  iter_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iter_q <= ITW'(ITER_MAX - 1));

  // R9
  done_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (state_q == SCH_IDLE) && !done);

  // R10
  len_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != SCH_IDLE) |=> (state_q == SCH_IDLE) || $stable(len_q));

  // R3
  start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == SCH_IDLE) && start && (seq_len != '0)) |=>
      ((state_q == SCH_RUN) && (ptr_q == '0) && (iter_q == '0)));

  // R8
  drain_no_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SCH_DRAIN) |=> (state_q != SCH_RUN));

endmodule

// File: rtl/ldpc_layer_sched.sv
module ldpc_layer_sched #(
  parameter int Z_SIZE     = 42,
  parameter int NUM_COLS   = 16,
  parameter int MAX_LAYERS = 8,
  parameter int SEQ_DEPTH  = 64,
  parameter int ITER_MAX   = 5,
  parameter int PIPE_DEPTH = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       early_term,
  input  logic [6:0] seq_len,
  input  logic       ld_valid,
  output logic       ld_ready,
  input  logic [5:0] ld_idx,
  input  logic [2:0] ld_layer,
  input  logic [3:0] ld_col,
  input  logic [5:0] ld_shift,
  input  logic       ld_eol,
  output logic       mem_rd_en,
  output logic [3:0] mem_rd_addr,
  output logic [2:0] mem_rd_layer,
  output logic [5:0] shift_amt,
  output logic       mem_wr_en,
  output logic [3:0] mem_wr_addr,
  output logic       stall,
  output logic [2:0] iter_count,
  output logic       done
);

  import ldpc_sched_pkg::*;

  localparam int CW   = idx_bits(NUM_COLS);
  localparam int SW   = idx_bits(Z_SIZE);
  localparam int LW   = idx_bits(MAX_LAYERS);
  localparam int IW   = idx_bits(SEQ_DEPTH);
  localparam int LENW = idx_bits(SEQ_DEPTH + 1);
  localparam int ITW  = idx_bits(ITER_MAX);

  logic [IW-1:0]  ptr;
  logic [LW-1:0]  r_layer;
  logic [CW-1:0]  r_col;
  logic [SW-1:0]  r_shift;
  logic           r_eol;
  logic           hazard, issue, final_tag;
  logic           ret_valid, ret_final;
  logic [CW-1:0]  ret_col;
  logic           idle;
  logic [ITW-1:0] iter_w;

  ldpc_seq_store #(
    .DEPTH(SEQ_DEPTH), .LW(LW), .CW(CW), .SW(SW), .IW(IW)
  ) store_i (
    .clk    (clk),
    .we     (ld_valid && ld_ready),
    .widx   (IW'(ld_idx)),
    .wlayer (LW'(ld_layer)),
    .wcol   (CW'(ld_col)),
    .wshift (SW'(ld_shift)),
    .weol   (ld_eol),
    .ridx   (ptr),
    .rlayer (r_layer),
    .rcol   (r_col),
    .rshift (r_shift),
    .reol   (r_eol)
  );

  ldpc_hazard_pipe #(
    .DEPTH(PIPE_DEPTH), .CW(CW)
  ) pipe_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .push       (issue),
    .push_col   (r_col),
    .push_final (final_tag),
    .probe_col  (r_col),
    .hazard     (hazard),
    .ret_valid  (ret_valid),
    .ret_col    (ret_col),
    .ret_final  (ret_final)
  );

  ldpc_sched_ctrl #(
    .ITER_MAX(ITER_MAX), .IW(IW), .LENW(LENW), .ITW(ITW)
  ) ctrl_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .early_term (early_term),
    .seq_len    (LENW'(seq_len)),
    .cur_eol    (r_eol),
    .hazard     (hazard),
    .ret_valid  (ret_valid),
    .ret_final  (ret_final),
    .issue      (issue),
    .final_tag  (final_tag),
    .ptr        (ptr),
    .iter_count (iter_w),
    .stall      (stall),
    .done       (done),
    .idle       (idle)
  );

  assign ld_ready     = idle;
  assign mem_rd_en    = issue;
  assign mem_rd_addr  = 4'(r_col);
  assign mem_rd_layer = 3'(r_layer);
  assign shift_amt    = 6'(r_shift);
  assign mem_wr_en    = ret_valid;
  assign mem_wr_addr  = 4'(ret_col);
  assign iter_count   = 3'(iter_w);

  // R9
  done_on_writeback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> mem_wr_en);

  // R2
  no_load_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_en || stall) |-> !ld_ready);

endmodule

// File: tb/ldpc_layer_sched_tb.sv
module ldpc_layer_sched_tb_top;

  localparam int P   = 4;
  localparam int ITM = 5;
  localparam int ML  = 64;
  localparam int OBS = 4096;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, early_term = 1'b0, ld_valid = 1'b0, ld_eol = 1'b0;
  logic [6:0] seq_len = '0;
  logic [5:0] ld_idx = '0, ld_shift = '0;
  logic [2:0] ld_layer = '0;
  logic [3:0] ld_col = '0;
  logic ld_ready, mem_rd_en, mem_wr_en, stall, done;
  logic [3:0] mem_rd_addr, mem_wr_addr;
  logic [2:0] mem_rd_layer, iter_count;
  logic [5:0] shift_amt;

  always #2 clk = ~clk;

  ldpc_layer_sched dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .early_term(early_term),
    .seq_len(seq_len), .ld_valid(ld_valid), .ld_ready(ld_ready),
    .ld_idx(ld_idx), .ld_layer(ld_layer), .ld_col(ld_col),
    .ld_shift(ld_shift), .ld_eol(ld_eol), .mem_rd_en(mem_rd_en),
    .mem_rd_addr(mem_rd_addr), .mem_rd_layer(mem_rd_layer),
    .shift_amt(shift_amt), .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr),
    .stall(stall), .iter_count(iter_count), .done(done)
  );

  int n_chk = 0, n_fail = 0, cyc = 0;

  int s_layer [ML], s_col [ML], s_shift [ML], s_eol [ML];

  int o_rd_cyc [OBS], o_rd_col [OBS], o_rd_lay [OBS], o_rd_sh [OBS];
  int o_wr_cyc [OBS], o_wr_col [OBS];
  int o_rd_n = 0, o_wr_n = 0, o_done_n = 0, o_done_cyc = 0, o_done_iter = 0, o_stall_n = 0;

  int e_cyc [OBS], e_idx [OBS];
  int e_n, e_done, e_iter;

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected below 150000", cyc);
      finish_run();
    end
  end

  always @(negedge clk) begin
    if (mem_rd_en && o_rd_n < OBS) begin
      o_rd_cyc[o_rd_n] = cyc; o_rd_col[o_rd_n] = int'(mem_rd_addr);
      o_rd_lay[o_rd_n] = int'(mem_rd_layer); o_rd_sh[o_rd_n] = int'(shift_amt);
      o_rd_n++;
    end
    if (mem_wr_en && o_wr_n < OBS) begin
      o_wr_cyc[o_wr_n] = cyc; o_wr_col[o_wr_n] = int'(mem_wr_addr);
      o_wr_n++;
    end
    if (done) begin
      o_done_cyc = cyc; o_done_iter = int'(iter_count); o_done_n++;
    end
    if (stall) o_stall_n++;
  end

  // expected issue cycles from R3/R4/R5/R7/R8, final write-back from R6/R9
  task automatic model(input int len, input int s, input int e);
    int lastc [16];
    int prev, idx, it, c;
    bit fin;
    for (int k = 0; k < 16; k++) lastc[k] = -1000;
    prev = s; idx = 0; it = 0; e_n = 0; fin = 0;
    while (!fin) begin
      c = prev + 1;
      if (lastc[s_col[idx]] + P + 1 > c) c = lastc[s_col[idx]] + P + 1;
      e_cyc[e_n] = c; e_idx[e_n] = idx; e_n++;
      lastc[s_col[idx]] = c; prev = c;
      fin = ((idx == len - 1) && (it == ITM - 1)) ||
            ((c >= e) && ((s_eol[idx] != 0) || (idx == len - 1)));
      e_iter = it;
      if (fin) e_done = c + P;
      else if (idx == len - 1) begin idx = 0; it++; end
      else idx++;
    end
  endtask

  task automatic load_seq(input int len);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      ld_valid = 1'b1; ld_idx = 6'(i); ld_layer = 3'(s_layer[i]);
      ld_col = 4'(s_col[i]); ld_shift = 6'(s_shift[i]); ld_eol = s_eol[i][0];
    end
    @(negedge clk);
    ld_valid = 1'b0;
  endtask

  task automatic gen_random(input int len);
    int lay;
    lay = 0;
    for (int i = 0; i < len; i++) begin
      s_col[i] = int'($urandom % 16);
      s_shift[i] = int'($urandom % 42);
      s_layer[i] = lay;
      s_eol[i] = (i == len - 1) ? 1 : int'(($urandom % 3) == 0);
      if (s_eol[i] != 0) lay = (lay + 1) % 8;
    end
  endtask

  task automatic run_case(input string tag, input int len, input int et_off, input bit poke);
    int rb, wb, db, sb, s, e, last_iss;
    bit fin;
    rb = o_rd_n; wb = o_wr_n; db = o_done_n; sb = o_stall_n;
    @(negedge clk);
    s = cyc; seq_len = 7'(len); start = 1'b1;
    e = (et_off < 0) ? 32'h3fff_ffff : s + et_off;
    model(len, s, e);
    fin = 0;
    for (int k = 0; k < 5000 && !fin; k++) begin
      @(negedge clk);
      seq_len = 7'((len % 3) + 1);                       // R10 mid-run change
      start = poke && (cyc == s + 3);                     // R3 ignored while busy
      early_term = (cyc == e);
      ld_valid = poke && (cyc == s + 2);
      ld_idx = 6'd0; ld_col = 4'(s_col[0] ^ 5); ld_shift = 6'd7; ld_eol = 1'b0;
      if (ld_valid) check("R2", "ld_ready during decode", int'(ld_ready), 0);
      if ((o_done_n > db) && (cyc > o_done_cyc + 1)) fin = 1;
    end
    start = 1'b0; early_term = 1'b0; ld_valid = 1'b0;
    check("R4", {tag, " read count"}, o_rd_n - rb, e_n);
    for (int k = 0; k < e_n && rb + k < o_rd_n; k++) begin
      check("R5", {tag, " read cycle"}, o_rd_cyc[rb + k] - s, e_cyc[k] - s);
      check("R4", {tag, " read column"}, o_rd_col[rb + k], s_col[e_idx[k]]);
      check("R4", {tag, " read layer"}, o_rd_lay[rb + k], s_layer[e_idx[k]]);
      check("R4", {tag, " read shift"}, o_rd_sh[rb + k], s_shift[e_idx[k]]);
    end
    check("R6", {tag, " write count"}, o_wr_n - wb, e_n);
    for (int k = 0; k < e_n && wb + k < o_wr_n; k++) begin
      check("R6", {tag, " write cycle"}, o_wr_cyc[wb + k] - s, e_cyc[k] + P - s);
      check("R6", {tag, " write column"}, o_wr_col[wb + k], s_col[e_idx[k]]);
    end
    last_iss = e_cyc[e_n - 1];
    check("R5", {tag, " stall cycles"}, o_stall_n - sb, (last_iss - s) - e_n);
    check("R9", {tag, " done pulses"}, o_done_n - db, 1);
    check("R9", {tag, " done cycle"}, o_done_cyc - s, e_done - s);
    check("R7", {tag, " iter at done"}, o_done_iter, e_iter);
    check("R9", {tag, " ready after done"}, int'(ld_ready), 1);
    check("R7", {tag, " iter held"}, int'(iter_count), e_iter);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "rd_en", int'(mem_rd_en), 0);
    check("R1", "wr_en", int'(mem_wr_en), 0);
    check("R1", "stall", int'(stall), 0);
    check("R1", "done", int'(done), 0);
    check("R1", "iter_count", int'(iter_count), 0);
    check("R1", "ld_ready", int'(ld_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);

    // directed: two layers with column reuse across layers
    s_col[0] = 0; s_col[1] = 3; s_col[2] = 5; s_col[3] = 3; s_col[4] = 7; s_col[5] = 0;
    for (int i = 0; i < 6; i++) begin
      s_layer[i] = i / 3; s_shift[i] = 5 * i + 1; s_eol[i] = int'(i == 2 || i == 5);
    end
    load_seq(6);
    run_case("two-layer full", 6, -1, 1'b1);
    run_case("two-layer R8 early first layer", 6, 2, 1'b0);
    run_case("two-layer R8 early later iter", 6, 17, 1'b1);
    run_case("two-layer R2 untouched by busy load", 6, -1, 1'b0);

    // R3: zero length start is ignored
    begin
      int rb;
      rb = o_rd_n;
      @(negedge clk); seq_len = 7'd0; start = 1'b1;
      @(negedge clk); start = 1'b0;
      repeat (6) @(negedge clk);
      check("R3", "zero-length reads", o_rd_n - rb, 0);
      check("R3", "zero-length ld_ready", int'(ld_ready), 1);
    end

    // single entry: every issue waits for its own write-back
    s_col[0] = 9; s_layer[0] = 2; s_shift[0] = 41; s_eol[0] = 1;
    load_seq(1);
    run_case("single-entry", 1, -1, 1'b0);

    // distinct columns, no stalls expected
    for (int i = 0; i < 16; i++) begin
      s_col[i] = 15 - i; s_layer[i] = i / 4; s_shift[i] = (i * 11) % 42;
      s_eol[i] = int'((i % 4) == 3);
    end
    load_seq(16);
    run_case("distinct-cols", 16, -1, 1'b1);

    // full depth sequence
    gen_random(64);
    load_seq(64);
    run_case("full-depth", 64, -1, 1'b1);

    // constrained random mix
    for (int r = 0; r < 10; r++) begin
      int len, et;
      len = 1 + int'($urandom % 24);
      gen_random(len);
      load_seq(len);
      et = (($urandom % 2) == 0) ? -1 : 1 + int'($urandom % (len * 3 + 4));
      run_case("random", len, et, r[0]);
    end

    repeat (4) @(negedge clk);
    finish_run();
  end

endmodule